// File: doc/BRIEF.md
# Byte-Parity Bus Transceiver with Storage Stages

This block passes a 16-bit word between two ports, A and B, in either direction. Each direction has its own storage stage, and that stage can run in one of three ways. It can be transparent, it can sit latched, or it can be loaded on the rising edge of its own clock. Each byte of the word carries one parity bit. A single select chooses odd or even parity for both directions at once.

In the A-to-B direction a mode input picks one of two jobs. The block either computes fresh parity for the B side, or it checks the parity that arrived on A. The B-to-A direction only ever checks. Each direction reports a failing byte on one error flag. That flag is modelled as an open-drain pull-down, and it is gated by the direction's active-low output enable. Every tri-state pin is split into a value and a drive-enable signal.

Top module: `bus_xcvr_parity`

## Requirements
- R1: When a direction's latch enable is high, that direction's output data and parity follow its input in the same cycle, with no clock edge needed.
- R2: When a direction's latch enable is low, that direction's output holds the input sampled at the most recent rising edge of its own clock. It changes only at such an edge.
- R3: The B-side drive enable equals the inverse of the A-to-B output enable (active low). The A-side drive enable equals the inverse of the B-to-A output enable.
- R4: With the generate select high, each B-side parity bit is computed from its byte. With odd selected, the byte plus its parity bit holds an odd number of ones; with even selected, an even number.
- R5: With the generate select low, the B-side parity bits are the stored A-side parity bits, passed through unchanged.
- R6: The A-to-B error flag reports a parity mismatch on either byte only while the generate select is low. In generate mode it never asserts.
- R7: The B-to-A direction always checks its parity, whatever the generate select says, and its parity bits pass through unchanged to the A side.
- R8: Byte 0 is data bits 7:0 and goes with parity bit 0. Byte 1 is data bits 15:8 and goes with parity bit 1. A mismatch is a byte whose ones count, including its parity bit, is even under odd mode or odd under even mode.
- R9: An error flag pulls low only while its direction's output enable is low. A raised flag therefore always comes with an enabled data drive in the same direction.
- R10: While reset is low, both storage stages clear to zero data and zero parity.
- R11: The check runs on the contents of the storage stage. While the stage is holding, a change at the input does not change the flag until the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both storage stages |
| clk_ab | input | 1 | A-to-B stage clock |
| le_ab | input | 1 | A-to-B latch enable, high = transparent |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| clk_ba | input | 1 | B-to-A stage clock |
| le_ba | input | 1 | B-to-A latch enable, high = transparent |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| gen_mode | input | 1 | A-to-B parity: 1 generate, 0 check |
| odd_sel | input | 1 | Parity sense for both directions: 1 odd, 0 even |
| a_data_i | input | 16 | Data arriving on port A |
| a_par_i | input | 2 | Byte parity arriving on port A |
| a_data_o | output | 16 | Data driven onto port A |
| a_par_o | output | 2 | Byte parity driven onto port A |
| a_drv_o | output | 1 | Drive enable for port A data and parity |
| b_data_i | input | 16 | Data arriving on port B |
| b_par_i | input | 2 | Byte parity arriving on port B |
| b_data_o | output | 16 | Data driven onto port B |
| b_par_o | output | 2 | Byte parity driven onto port B |
| b_drv_o | output | 1 | Drive enable for port B data and parity |
| err_ab_pull_o | output | 1 | A-to-B error flag, 1 = pull the open-drain line low |
| err_ba_pull_o | output | 1 | B-to-A error flag, 1 = pull the open-drain line low |

## Verification
A corrupted storage stage shows up on that direction's data and parity outputs right away in latched or clocked operation. It also shows on the error flag, because the check reads the stored bits rather than the pins. A stage that loads at the wrong time is exposed inside one clock period. Data is changed between edges and then sampled both before and after the next rising edge. A wrong parity sense or byte pairing flips a parity bit or the flag as soon as a pattern with an odd ones count in only one byte is applied.

// File: rtl/bus_xcvr_parity.sv
module bus_xcvr_parity #(
  parameter int BYTE_W = 8,
  parameter int BYTES  = 2
) (
  input  logic                     rst_n,
  input  logic                     clk_ab,
  input  logic                     le_ab,
  input  logic                     oe_ab_n,
  input  logic                     clk_ba,
  input  logic                     le_ba,
  input  logic                     oe_ba_n,
  input  logic                     gen_mode,
  input  logic                     odd_sel,
  input  logic [BYTE_W*BYTES-1:0]  a_data_i,
  input  logic [BYTES-1:0]         a_par_i,
  output logic [BYTE_W*BYTES-1:0]  a_data_o,
  output logic [BYTES-1:0]         a_par_o,
  output logic                     a_drv_o,
  input  logic [BYTE_W*BYTES-1:0]  b_data_i,
  input  logic [BYTES-1:0]         b_par_i,
  output logic [BYTE_W*BYTES-1:0]  b_data_o,
  output logic [BYTES-1:0]         b_par_o,
  output logic                     b_drv_o,
  output logic                     err_ab_pull_o,
  output logic                     err_ba_pull_o
);
  localparam int DW = BYTE_W * BYTES;

  function automatic logic [BYTES-1:0] want_par(input logic [DW-1:0] d, input logic odd);
    logic [BYTES-1:0] r;
    for (int i = 0; i < BYTES; i++) r[i] = (^d[i*BYTE_W +: BYTE_W]) ^ odd;
    return r;
  endfunction

  logic [DW-1:0]    ab_q, ba_q, ab_d, ba_d;
  logic [BYTES-1:0] abp_q, bap_q, ab_p, ba_p, ab_gen;
  logic             ab_bad, ba_bad;

  always_ff @(posedge clk_ab or negedge rst_n)
    if (!rst_n) begin
      ab_q  <= '0;
      abp_q <= '0;
    end else begin
      ab_q  <= a_data_i;
      abp_q <= a_par_i;
    end

  always_ff @(posedge clk_ba or negedge rst_n)
    if (!rst_n) begin
      ba_q  <= '0;
      bap_q <= '0;
    end else begin
      ba_q  <= b_data_i;
      bap_q <= b_par_i;
    end

  assign ab_d   = le_ab ? a_data_i : ab_q;
  assign ab_p   = le_ab ? a_par_i  : abp_q;
  assign ba_d   = le_ba ? b_data_i : ba_q;
  assign ba_p   = le_ba ? b_par_i  : bap_q;

  assign ab_gen = want_par(ab_d, odd_sel);
  assign ab_bad = |(ab_gen ^ ab_p);
  assign ba_bad = |(want_par(ba_d, odd_sel) ^ ba_p);

  assign b_data_o = ab_d;
  assign b_par_o  = gen_mode ? ab_gen : ab_p;
  assign b_drv_o  = ~oe_ab_n;
  assign a_data_o = ba_d;
  assign a_par_o  = ba_p;
  assign a_drv_o  = ~oe_ba_n;

  assign err_ab_pull_o = ~oe_ab_n & ~gen_mode & ab_bad;
  assign err_ba_pull_o = ~oe_ba_n & ba_bad;

  // R2
  clocked_ab_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!le_ab && $past(rst_n)) |-> (b_data_o == $past(a_data_i)));

  // R2
  clocked_ba_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!le_ba && $past(rst_n)) |-> (a_data_o == $past(b_data_i)));

  // R6
  gen_no_err_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    gen_mode |-> !err_ab_pull_o);

  // R9
  ab_flag_gate_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    err_ab_pull_o |-> b_drv_o);

  // R9
  ba_flag_gate_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    err_ba_pull_o |-> a_drv_o);

  for (genvar g = 0; g < BYTES; g++) begin : g_par_chk
    // R4
    gen_sense_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
      gen_mode |-> ((^{b_data_o[g*BYTE_W +: BYTE_W], b_par_o[g]}) == odd_sel));
  end
endmodule

// File: tb/bus_xcvr_parity_tb.sv
`timescale 1ns/1ps
module bus_xcvr_parity_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, le_ab, oe_ab_n, le_ba, oe_ba_n, gen_mode, odd_sel;
  logic [15:0] a_data_i, b_data_i, a_data_o, b_data_o;
  logic [1:0]  a_par_i, b_par_i, a_par_o, b_par_o;
  logic        a_drv_o, b_drv_o, err_ab_pull_o, err_ba_pull_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bus_xcvr_parity dut_i (
    .rst_n(rst_n), .clk_ab(clk), .le_ab(le_ab), .oe_ab_n(oe_ab_n),
    .clk_ba(clk), .le_ba(le_ba), .oe_ba_n(oe_ba_n),
    .gen_mode(gen_mode), .odd_sel(odd_sel),
    .a_data_i(a_data_i), .a_par_i(a_par_i), .a_data_o(a_data_o),
    .a_par_o(a_par_o), .a_drv_o(a_drv_o),
    .b_data_i(b_data_i), .b_par_i(b_par_i), .b_data_o(b_data_o),
    .b_par_o(b_par_o), .b_drv_o(b_drv_o),
    .err_ab_pull_o(err_ab_pull_o), .err_ba_pull_o(err_ba_pull_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_par(input logic [15:0] d, input logic odd);
    ref_par[0] = ($countones(d[7:0]) % 2 == 1) ? ~odd : odd;
    ref_par[1] = ($countones(d[15:8]) % 2 == 1) ? ~odd : odd;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; le_ab = 1'b0; le_ba = 1'b0; oe_ab_n = 1'b1; oe_ba_n = 1'b1;
    gen_mode = 1'b0; odd_sel = 1'b1;
    a_data_i = 16'hA5C3; a_par_i = 2'b11; b_data_i = 16'h5A3C; b_par_i = 2'b11;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R10 b data in reset", b_data_o, 16'h0000);
    chk("R10 a data in reset", a_data_o, 16'h0000);
    chk("R3 b drive off", b_drv_o, 1'b0);
    chk("R9 flags off in reset", {err_ab_pull_o, err_ba_pull_o}, 2'b00);
    rst_n = 1'b1;
  endtask

  task automatic t_transparent;
    @(negedge clk);
    oe_ab_n = 1'b0; oe_ba_n = 1'b0; le_ab = 1'b1; le_ba = 1'b1; gen_mode = 1'b0;
    a_data_i = 16'h1234; a_par_i = 2'b10; b_data_i = 16'hBEEF; b_par_i = 2'b01;
    #1;
    chk("R1 b follows a", b_data_o, 16'h1234);
    chk("R1 b parity follows", b_par_o, 2'b10);
    chk("R1 a follows b", a_data_o, 16'hBEEF);
    chk("R3 drives on", {a_drv_o, b_drv_o}, 2'b11);
  endtask

  task automatic t_clocked;
    @(negedge clk);
    le_ab = 1'b0; le_ba = 1'b0; a_data_i = 16'h0F0F; b_data_i = 16'h7001;
    @(negedge clk);
    a_data_i = 16'hF00D; b_data_i = 16'h2222; #1;
    chk("R2 b holds before edge", b_data_o, 16'h0F0F);
    chk("R2 a holds before edge", a_data_o, 16'h7001);
    @(posedge clk); #1;
    chk("R2 b loads at edge", b_data_o, 16'hF00D);
    chk("R2 a loads at edge", a_data_o, 16'h2222);
  endtask

  task automatic t_generate;
    @(negedge clk);
    le_ab = 1'b1; gen_mode = 1'b1; odd_sel = 1'b1;
    a_data_i = 16'h0301; a_par_i = 2'b00; #1;
    chk("R4 R8 odd generate", b_par_o, 2'b10);
    chk("R6 no flag in generate", err_ab_pull_o, 1'b0);
    odd_sel = 1'b0; #1;
    chk("R4 R8 even generate", b_par_o, 2'b01);
    a_data_i = 16'hFF7F; #1;
    chk("R4 even generate alt", b_par_o, ref_par(16'hFF7F, 1'b0));
  endtask

  task automatic t_check_ab;
    @(negedge clk);
    le_ab = 1'b1; gen_mode = 1'b0; odd_sel = 1'b1;
    a_data_i = 16'h0301; a_par_i = 2'b10; #1;
    chk("R5 parity passes", b_par_o, 2'b10);
    chk("R6 good parity no flag", err_ab_pull_o, 1'b0);
    a_par_i = 2'b11; #1;
    chk("R6 R8 byte0 bad", err_ab_pull_o, 1'b1);
    chk("R5 bad parity passes", b_par_o, 2'b11);
    a_par_i = 2'b00; #1;
    chk("R6 R8 byte1 bad", err_ab_pull_o, 1'b1);
    odd_sel = 1'b0; a_par_i = 2'b01; #1;
    chk("R8 even sense good", err_ab_pull_o, 1'b0);
    oe_ab_n = 1'b1; a_par_i = 2'b00; #1;
    chk("R9 ab flag gated", err_ab_pull_o, 1'b0);
    chk("R3 b drive off", b_drv_o, 1'b0);
    oe_ab_n = 1'b0; #1;
    chk("R9 ab flag enabled", err_ab_pull_o, 1'b1);
  endtask

  task automatic t_check_ba;
    @(negedge clk);
    le_ba = 1'b1; odd_sel = 1'b1; gen_mode = 1'b1;
    b_data_i = 16'h0100; b_par_i = 2'b01; #1;
    chk("R7 ba good no flag", err_ba_pull_o, 1'b0);
    chk("R7 ba parity passes", a_par_o, 2'b01);
    b_par_i = 2'b11; #1;
    chk("R7 ba checks in generate", err_ba_pull_o, 1'b1);
    gen_mode = 1'b0; #1;
    chk("R7 ba checks in check", err_ba_pull_o, 1'b1);
    oe_ba_n = 1'b1; #1;
    chk("R9 ba flag gated", err_ba_pull_o, 1'b0);
    chk("R3 a drive off", a_drv_o, 1'b0);
    oe_ba_n = 1'b0;
  endtask

  task automatic t_hold_check;
    @(negedge clk);
    le_ab = 1'b0; gen_mode = 1'b0; odd_sel = 1'b1;
    a_data_i = 16'h0001; a_par_i = 2'b00;
    @(posedge clk); #1;
    chk("R11 stored bad flagged", err_ab_pull_o, 1'b1);
    @(negedge clk);
    a_par_i = 2'b10; #1;
    chk("R11 flag held between edges", err_ab_pull_o, 1'b1);
    @(posedge clk); #1;
    chk("R11 flag clears at edge", err_ab_pull_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_transparent();
    t_clocked();
    t_generate();
    t_check_ab();
    t_check_ba();
    t_hold_check();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule